// File: doc/BRIEF.md
# USB Host Pipe Status and Interrupt Flags

This block holds the status flags of one pipe of a USB host controller. The pipe engine reports events to it as one-cycle strobes: a NAK handshake, a free SETUP bank, a free OUT bank, a STALL handshake, a CRC error on an isochronous pipe, and received IN data. Each strobe sets a sticky flag. Firmware reads all the flags through one 8-bit status word. It acknowledges a flag by writing 0 to that flag's bit. Writing 1 to a flag bit never sets it.

The block also produces four further outputs:
- An error flag that tracks an external error-source vector.
- A read/write-allowed indication for the current FIFO bank.
- A two-bank pointer. It advances when firmware writes 0 to the bank-release bit.
- A freeze output. A STALL sets it, and only a dedicated clear input releases it.

One interrupt line is the OR of every interrupt-capable flag gated by its matching bit in an externally held enable word.

Top module: `pipe_flag_reg`

## Requirements
- R1: A strobe on `hw_nak`, `hw_setup_free`, `hw_out_free` or `hw_in_rcvd` sets status bit 6, 3, 2 or 0 respectively on the next clock edge. The bit stays set until it is cleared.
- R2: A write with bit n of `wr_data` at 0 clears event flag n (n = 6, 3, 2, 1, 0) on the next edge. A 1 in that position leaves the flag unchanged.
- R3: When a set strobe and a software clear reach the same flag in the same cycle, the flag is set afterwards.
- R4: `irq` is high exactly when one of status bits 6, 4, 3, 2, 1, 0 is set together with the `int_en` bit at the same position. `int_en` bits 7 and 5 have no effect.
- R5: On a non-isochronous pipe (`iso_mode`=0), `hw_stall` sets status bit 1 and asserts `freeze` on the next edge.
- R6: With `iso_mode`=1, `hw_crc_err` sets status bit 1, and `hw_stall` changes neither bit 1 nor `freeze`. With `iso_mode`=0, `hw_crc_err` is ignored.
- R7: `freeze` stays high until a cycle with `frz_clr`=1 and no freezing STALL. Clearing status bit 1 does not release it.
- R8: Status bit 4 equals, one cycle later, the OR of all bits of `err_src`. Software writes do not change it.
- R9: Status bit 5 is `!bank_full` when `dir_in`=0 and `!bank_empty` when `dir_in`=1. It is forced to 0 while bit 1 or bit 4 is set. Writes do not affect it.
- R10: A write with `wr_data[7]`=0 drives `bank_release` high in that cycle and advances `bank_ptr` on the next edge. A write with `wr_data[7]`=1 does neither. Status bit 7 always reads 0.
- R11: While `rst_n` is low at a clock edge, all event flags, the error flag, `freeze` and `bank_ptr` return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_nak | input | 1 | NAK handshake received strobe |
| hw_setup_free | input | 1 | SETUP bank free strobe |
| hw_out_free | input | 1 | OUT bank free strobe |
| hw_stall | input | 1 | STALL handshake received strobe |
| hw_crc_err | input | 1 | Isochronous CRC error strobe |
| hw_in_rcvd | input | 1 | IN data received strobe |
| err_src | input | ERR_W | External error-source bits |
| iso_mode | input | 1 | Pipe is isochronous |
| dir_in | input | 1 | 1 = IN pipe, 0 = OUT pipe |
| bank_full | input | 1 | Current bank full |
| bank_empty | input | 1 | Current bank empty |
| int_en | input | 8 | Interrupt enable word, same bit positions as status |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 8 | Status write data |
| frz_clr | input | 1 | Release freeze |
| rd_data | output | 8 | Status word |
| irq | output | 1 | Pipe interrupt |
| freeze | output | 1 | Pipe frozen |
| bank_ptr | output | BANK_PTR_W | Current bank index |
| bank_release | output | 1 | Current bank freed this cycle |

## Verification
The bench targets these corner cases, each paired with the fault it would expose:
- Set and clear hitting the same flag in the same cycle. A design with the priority reversed would silently lose events.
- Writing all ones to the status word. A design that treated writes as ordinary register loads would raise flags on its own.
- Swapping `iso_mode` around STALL and CRC strobes. This catches a design that freezes an isochronous pipe or ignores the CRC error.
- Clearing the STALL flag before asserting `frz_clr`. This catches a freeze tied to the flag.
- Holding error sources while the FIFO level changes. This catches read/write-allowed leaking through during an error.
- Writes with bit 7 low that are meant only to clear flags. These confirm that such writes also release the bank, so a design that decoded the release bit as active-high would desynchronise the bank pointer.

// File: rtl/pipe_flag_pkg.sv
// Package: bit positions of the pipe status word and shared constants.
// Assumes an 8-bit status word; positions are decoded by firmware.
package pipe_flag_pkg;
    localparam int STAT_W  = 8;
    localparam int POS_REL   = 7;
    localparam int POS_NAK   = 6;
    localparam int POS_RWAL  = 5;
    localparam int POS_ERR   = 4;
    localparam int POS_SETUP = 3;
    localparam int POS_OUTR  = 2;
    localparam int POS_STALL = 1;
    localparam int POS_INR   = 0;

    // bits held by sticky event flags
    localparam logic [STAT_W-1:0] EVT_MASK = 8'b0100_1111;
    // bits that may raise the interrupt
    localparam logic [STAT_W-1:0] IRQ_MASK = 8'b0101_1111;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } pipe_dir_e;
endpackage

// File: rtl/pipe_evt_flag.sv
// Module: one sticky event flag, set by hardware, cleared by software.
// Assumes set and clear are single-cycle qualified strobes; set has priority.
module pipe_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // Hold flag: reset low, hardware set wins over software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R1 R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R2
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/pipe_err_track.sv
// Module: pipe error flag that mirrors the external error-source vector.
// Assumes err_src is synchronous; the flag is read-only to software.
module pipe_err_track #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_src,
    output logic             err_o
);
    logic err_q;

    // Register the OR of all error sources; clears once all sources are zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= |err_src;
    end

    assign err_o = err_q;

    // R8
    err_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_src) |=> err_o);
    // R8
    err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_src == '0) |=> !err_o);
endmodule

// File: rtl/pipe_bank_ctl.sv
// Module: bank pointer and pipe freeze control.
// Assumes release and stall inputs are already qualified strobes.
module pipe_bank_ctl #(
    parameter int BANK_CNT = 2,
    localparam int PTR_W   = (BANK_CNT > 1) ? $clog2(BANK_CNT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             release_i,
    input  logic             stall_i,
    input  logic             frz_clr_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             freeze_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(BANK_CNT - 1);

    logic [PTR_W-1:0] ptr_q;
    logic             frz_q;

    // Advance the bank pointer on each release, wrapping after the last bank.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (release_i)
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
    end

    // Freeze on a STALL; only the explicit clear releases it, STALL wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frz_q <= 1'b0;
        else if (stall_i)
            frz_q <= 1'b1;
        else if (frz_clr_i)
            frz_q <= 1'b0;
    end

    assign ptr_o    = ptr_q;
    assign freeze_o = frz_q;

    // R5
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> freeze_o);
    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_o && !frz_clr_i) |=> freeze_o);
    // R10
    bank_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> (ptr_o != $past(ptr_o)));
    // R10
    bank_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !release_i |=> $stable(ptr_o));
endmodule

// File: rtl/pipe_flag_reg.sv
// Module: per-pipe status/interrupt flag register of a USB host controller.
// Collects pipe-engine strobes into sticky flags, exposes a status word,
// derives read/write-allowed, drives the interrupt, bank pointer and freeze.
// Assumes all inputs are synchronous to clk; enables are held externally.
module pipe_flag_reg
    import pipe_flag_pkg::*;
#(
    parameter int ERR_W      = 4,
    parameter int BANK_CNT   = 2,
    localparam int BANK_PTR_W = (BANK_CNT > 1) ? $clog2(BANK_CNT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hw_nak,
    input  logic                  hw_setup_free,
    input  logic                  hw_out_free,
    input  logic                  hw_stall,
    input  logic                  hw_crc_err,
    input  logic                  hw_in_rcvd,
    input  logic [ERR_W-1:0]      err_src,
    input  logic                  iso_mode,
    input  logic                  dir_in,
    input  logic                  bank_full,
    input  logic                  bank_empty,
    input  logic [STAT_W-1:0]     int_en,
    input  logic                  wr_en,
    input  logic [STAT_W-1:0]     wr_data,
    input  logic                  frz_clr,
    output logic [STAT_W-1:0]     rd_data,
    output logic                  irq,
    output logic                  freeze,
    output logic [BANK_PTR_W-1:0] bank_ptr,
    output logic                  bank_release
);
    logic [STAT_W-1:0] hw_set;
    logic [STAT_W-1:0] sw_clr;
    logic [STAT_W-1:0] evt_q;
    logic              err_q;
    logic              stall_frz;
    logic              rwal;
    logic [STAT_W-1:0] status;

    // Map pipe-engine strobes onto status bit positions; bit 1 depends on mode.
    always_comb begin
        hw_set            = '0;
        hw_set[POS_NAK]   = hw_nak;
        hw_set[POS_SETUP] = hw_setup_free;
        hw_set[POS_OUTR]  = hw_out_free;
        hw_set[POS_STALL] = iso_mode ? hw_crc_err : hw_stall;
        hw_set[POS_INR]   = hw_in_rcvd;
    end

    // A software clear is a write with a zero in the flag's position.
    always_comb begin
        sw_clr = {STAT_W{wr_en}} & ~wr_data;
    end

    assign stall_frz    = hw_stall & ~iso_mode;
    assign bank_release = sw_clr[POS_REL];

    for (genvar b = 0; b < STAT_W; b++) begin : g_evt
        if (EVT_MASK[b]) begin : g_flag
            pipe_evt_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (hw_set[b]),
                .clr_i  (sw_clr[b]),
                .flag_o (evt_q[b])
            );
        end else begin : g_none
            assign evt_q[b] = 1'b0;
        end
    end

    pipe_err_track #(.ERR_W(ERR_W)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_src (err_src),
        .err_o   (err_q)
    );

    pipe_bank_ctl #(.BANK_CNT(BANK_CNT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .release_i (bank_release),
        .stall_i   (stall_frz),
        .frz_clr_i (frz_clr),
        .ptr_o     (bank_ptr),
        .freeze_o  (freeze)
    );

    // Read/write-allowed from the FIFO level, blocked by STALL or error.
    always_comb begin
        if (pipe_dir_e'(dir_in) == DIR_IN)
            rwal = ~bank_empty;
        else
            rwal = ~bank_full;
        if (evt_q[POS_STALL] || err_q)
            rwal = 1'b0;
    end

    // Assemble the status word; the release bit always reads zero.
    always_comb begin
        status           = evt_q;
        status[POS_RWAL] = rwal;
        status[POS_ERR]  = err_q;
        status[POS_REL]  = 1'b0;
    end

    assign rd_data = status;
    assign irq     = |(status & int_en & IRQ_MASK);

    // R9
    rwal_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[POS_STALL] || rd_data[POS_ERR]) |-> !rd_data[POS_RWAL]);
    // R10
    rel_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[POS_REL]);
    // R6
    iso_no_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_mode && !freeze) |=> !freeze);
    // R4
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((rd_data & int_en & IRQ_MASK) != '0));
endmodule

// File: tb/pipe_flag_reg_bench.sv
`timescale 1ns/1ps
module pipe_flag_reg_bench;
    localparam int ERR_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_nak = 0, hw_setup_free = 0, hw_out_free = 0, hw_stall = 0;
    logic hw_crc_err = 0, hw_in_rcvd = 0;
    logic [ERR_W-1:0] err_src = '0;
    logic iso_mode = 0, dir_in = 0, bank_full = 0, bank_empty = 1;
    logic [7:0] int_en = '0;
    logic wr_en = 0;
    logic [7:0] wr_data = '0;
    logic frz_clr = 0;
    logic [7:0] rd_data;
    logic irq, freeze, bank_release;
    logic [0:0] bank_ptr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state
    logic m_nak, m_setup, m_outr, m_stall, m_inr, m_err, m_frz, m_ptr;

    always #2.5 clk = ~clk;

    pipe_flag_reg u_pipe_flag_reg (
        .clk(clk), .rst_n(rst_n), .hw_nak(hw_nak), .hw_setup_free(hw_setup_free),
        .hw_out_free(hw_out_free), .hw_stall(hw_stall), .hw_crc_err(hw_crc_err),
        .hw_in_rcvd(hw_in_rcvd), .err_src(err_src), .iso_mode(iso_mode),
        .dir_in(dir_in), .bank_full(bank_full), .bank_empty(bank_empty),
        .int_en(int_en), .wr_en(wr_en), .wr_data(wr_data), .frz_clr(frz_clr),
        .rd_data(rd_data), .irq(irq), .freeze(freeze), .bank_ptr(bank_ptr),
        .bank_release(bank_release)
    );

    function automatic logic exp_rwal();
        logic r;
        r = dir_in ? !bank_empty : !bank_full;
        return r & !m_stall & !m_err;
    endfunction

    function automatic logic [7:0] exp_status();
        return {1'b0, m_nak, exp_rwal(), m_err, m_setup, m_outr, m_stall, m_inr};
    endfunction

    function automatic logic exp_irq();
        logic [7:0] s;
        s = exp_status();
        return |(s & int_en & 8'b0101_1111);
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        {m_nak, m_setup, m_outr, m_stall, m_inr, m_err, m_frz, m_ptr} = '0;
    endtask

    task automatic model_step();
        logic [7:0] c;
        c = wr_en ? ~wr_data : 8'h00;
        m_nak   = hw_nak        | (m_nak   & !c[6]);
        m_setup = hw_setup_free | (m_setup & !c[3]);
        m_outr  = hw_out_free   | (m_outr  & !c[2]);
        m_inr   = hw_in_rcvd    | (m_inr   & !c[0]);
        m_stall = (iso_mode ? hw_crc_err : hw_stall) | (m_stall & !c[1]);
        m_err   = |err_src;
        m_frz   = (!iso_mode & hw_stall) | (m_frz & !frz_clr);
        m_ptr   = m_ptr ^ c[7];
    endtask

    task automatic check_all(input string tag);
        logic [7:0] e;
        e = exp_status();
        chk(tag, "R1 nak",      {7'b0, rd_data[6]}, {7'b0, e[6]});
        chk(tag, "R1 setup",    {7'b0, rd_data[3]}, {7'b0, e[3]});
        chk(tag, "R1 out",      {7'b0, rd_data[2]}, {7'b0, e[2]});
        chk(tag, "R1 in",       {7'b0, rd_data[0]}, {7'b0, e[0]});
        chk(tag, "R5 stall",    {7'b0, rd_data[1]}, {7'b0, e[1]});
        chk(tag, "R8 err",      {7'b0, rd_data[4]}, {7'b0, e[4]});
        chk(tag, "R9 rwal",     {7'b0, rd_data[5]}, {7'b0, e[5]});
        chk(tag, "R10 bit7",    {7'b0, rd_data[7]}, 8'h00);
        chk(tag, "R4 irq",      {7'b0, irq},        {7'b0, exp_irq()});
        chk(tag, "R7 freeze",   {7'b0, freeze},     {7'b0, m_frz});
        chk(tag, "R10 ptr",     {7'b0, bank_ptr},   {7'b0, m_ptr});
    endtask

    // inputs already driven after a negedge; check release, clock, update, check
    task automatic cycle(input string tag);
        #1;
        chk(tag, "R10 release", {7'b0, bank_release}, {7'b0, wr_en & !wr_data[7]});
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle();
        {hw_nak, hw_setup_free, hw_out_free, hw_stall, hw_crc_err, hw_in_rcvd} = '0;
        wr_en = 0; wr_data = 8'hFF; frz_clr = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        idle();
        int_en = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_all("R11 reset");
        chk("R11", "status", rd_data, 8'h20);

        // R1: each strobe sets its flag
        hw_nak = 1; hw_setup_free = 1; hw_out_free = 1; hw_in_rcvd = 1;
        cycle("R1 set");
        idle(); cycle("R1 hold");
        // R2: writing ones changes nothing, zero clears one flag
        wr_en = 1; wr_data = 8'hFF; cycle("R2 ones");
        idle(); wr_en = 1; wr_data = 8'hF7; cycle("R2 clear setup");
        chk("R2", "setup cleared", {7'b0, rd_data[3]}, 8'h00);
        // R3: set and clear together
        idle(); hw_nak = 1; wr_en = 1; wr_data = 8'hBF; cycle("R3 collide");
        chk("R3", "nak kept", {7'b0, rd_data[6]}, 8'h01);
        // R6: isochronous mode swaps bit 1 source
        idle(); iso_mode = 1; hw_stall = 1; cycle("R6 iso stall ignored");
        chk("R6", "no freeze", {7'b0, freeze}, 8'h00);
        idle(); hw_crc_err = 1; cycle("R6 iso crc");
        idle(); wr_en = 1; wr_data = 8'hFD; cycle("R6 clear crc");
        idle(); iso_mode = 0; hw_crc_err = 1; cycle("R6 crc ignored");
        // R5/R7: stall freezes; clearing flag keeps freeze
        idle(); hw_stall = 1; cycle("R5 stall");
        chk("R5", "freeze", {7'b0, freeze}, 8'h01);
        idle(); wr_en = 1; wr_data = 8'hFD; cycle("R7 flag cleared");
        chk("R7", "freeze held", {7'b0, freeze}, 8'h01);
        idle(); hw_stall = 1; frz_clr = 1; cycle("R7 stall wins");
        idle(); frz_clr = 1; cycle("R7 release");
        chk("R7", "freeze off", {7'b0, freeze}, 8'h00);
        // R8/R9: error blocks rwal, writes do not clear it
        idle(); wr_en = 1; wr_data = 8'hFD; err_src = 4'b0100; bank_full = 0; cycle("R8 err set");
        idle(); wr_en = 1; wr_data = 8'hEF; cycle("R8 write ignored");
        chk("R9", "rwal blocked", {7'b0, rd_data[5]}, 8'h00);
        idle(); err_src = '0; dir_in = 1; bank_empty = 0; cycle("R9 in pipe");
        // R10: release bit
        idle(); wr_en = 1; wr_data = 8'h7F; cycle("R10 release");
        idle(); wr_en = 1; wr_data = 8'hFF; cycle("R10 no release");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            idle();
            hw_nak        = ($urandom % 6) == 0;
            hw_setup_free = ($urandom % 6) == 0;
            hw_out_free   = ($urandom % 6) == 0;
            hw_in_rcvd    = ($urandom % 6) == 0;
            hw_stall      = ($urandom % 12) == 0;
            hw_crc_err    = ($urandom % 12) == 0;
            frz_clr       = ($urandom % 8) == 0;
            err_src       = (($urandom % 5) == 0) ? ERR_W'($urandom) : '0;
            if (($urandom % 50) == 0) iso_mode = ~iso_mode;
            if (($urandom % 30) == 0) dir_in = ~dir_in;
            bank_full  = $urandom % 2;
            bank_empty = $urandom % 2;
            if (($urandom % 20) == 0) int_en = 8'($urandom);
            wr_en   = ($urandom % 3) == 0;
            wr_data = 8'($urandom) | ((($urandom % 4) != 0) ? 8'h80 : 8'h00);
            cycle("RND");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule